// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Guard Unit

This block keeps the protection state of a small serial EEPROM: the write-enable latch, the two block-protect bits and the self-timed write-cycle timer. The serial command engine drives it with one-cycle pulses for the enable, disable, status-write and array-commit commands. It uses the status byte that comes back for status reads. It asks the unit whether the engine may start a write at all, and whether a given address lies inside the protected region.

A write cycle starts only when the unit accepts a status write or an array commit. It lasts a fixed number of system clocks, set by a parameter that stands in for the millisecond-scale programming time. While the cycle runs, every command is ignored and the status byte reads as all ones. When the cycle ends, the enable latch drops. The write-protect pin works differently on the two latch commands. It also cancels a write that is still being framed, but it has no effect on a cycle that has already started.

Top module: `ee_status_guard`

## Requirements
- R1: When idle, the status byte is {4'b0000, protect[1:0], enable, 1'b0}: bit 0 (busy) is 0, bit 1 is the enable latch, bits 3:2 are the protect code, and bits 7:4 read 0.
- R2: An accepted start raises `busy` in the next cycle and holds it for exactly WRITE_CYCLES clocks. During that time the status byte reads 8'hFF.
- R3: `addr_protected` follows the protect code. Code 00 protects nothing. Code 01 protects addresses whose two top bits are 11 (the top quarter). Code 10 protects addresses whose top bit is 1 (the top half). Code 11 protects every address.
- R4: After reset the enable latch is 0, and it returns to 0 on the clock that ends any write cycle.
- R5: `cmd_set_we` sets the latch only while `wp_n` is 1. `cmd_clr_we` clears it whatever `wp_n` is. If both arrive in the same cycle, clear wins.
- R6: `write_allowed` is 1 exactly when the latch is set, `wp_n` is 1, no cancel is pending and no cycle is running. A status write or an array commit that arrives while `write_allowed` is 0 changes nothing and starts no cycle.
- R7: An accepted status write loads only data bits 3:2 into the protect code. All other data bits are discarded.
- R8: If `wp_n` is 0 in any cycle while `frame_active` is 1, `write_allowed` drops and stays 0 until the next rising edge of `frame_active`. Changes on `wp_n` during a running cycle do not shorten or abort that cycle.
- R9: While `busy` is 1, set-enable, clear-enable, status-write and commit pulses are ignored.
- R10: After reset the protect code is 00 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_set_we | input | 1 | Pulse: set the write-enable latch |
| cmd_clr_we | input | 1 | Pulse: clear the write-enable latch |
| cmd_wr_status | input | 1 | Pulse: write the status byte on `wr_status_data` |
| wr_status_data | input | 8 | Data byte for a status write |
| cmd_commit | input | 1 | Pulse: start the self-timed array write |
| wp_n | input | 1 | Write-protect pin, active low |
| frame_active | input | 1 | 1 while a serial frame (chip select) is open |
| query_addr | input | ADDR_W | Address to test against the protect code |
| status_byte | output | 8 | Byte returned to status reads |
| busy | output | 1 | Write cycle in progress |
| write_allowed | output | 1 | A write or status write would be accepted now |
| addr_protected | output | 1 | `query_addr` lies in the protected region |

## Verification
The bench sweeps every address under each of the four protect codes. A decoder that slices the wrong address bits, or that mixes up the quarter and half codes, would flag the wrong band of addresses. It measures the exact busy length, and during that window it injects commands and a protect-pin drop. An off-by-one timer, or a guard that listens while busy, would give the wrong count or a corrupted protect code. It also covers the pin-low set-enable, the clear-wins collision and a status write with junk in the unused bits. The cancel scenario checks that a pin glitch inside a frame blocks the commit that ends the frame, and that the cancel clears at the next frame start. A design that kept the cancel forever, or never set it, would fail there.

// File: rtl/ee_status_pkg.sv
package ee_status_pkg;

   typedef enum logic [1:0] {
      PROT_NONE    = 2'b00,
      PROT_QUARTER = 2'b01,
      PROT_HALF    = 2'b10,
      PROT_ALL     = 2'b11
   } prot_level_e;

   localparam int unsigned ST_BUSY_BIT = 0;
   localparam int unsigned ST_WEL_BIT  = 1;
   localparam int unsigned ST_BP_LO    = 2;
   localparam int unsigned ST_BP_HI    = 3;
   localparam logic [7:0]  ST_WR_MASK  = 8'h0C;
   localparam logic [7:0]  ST_BUSY_VAL = 8'hFF;

endpackage

// File: rtl/ee_wcycle_timer.sv
module ee_wcycle_timer #(
   parameter int unsigned WRITE_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int unsigned CNT_W = (WRITE_CYCLES > 2) ? $clog2(WRITE_CYCLES) : 1;

   initial begin
      assert (WRITE_CYCLES >= 1) else $error("WRITE_CYCLES must be at least 1");
   end

   generate
      if (WRITE_CYCLES == 1) begin : g_single
         logic busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      busy_q <= 1'b0;
            else if (busy_q) busy_q <= 1'b0;
            else if (start)  busy_q <= 1'b1;
         end
         assign busy = busy_q;
         assign done = busy_q;
      end else begin : g_count
         localparam logic [CNT_W-1:0] LOAD = CNT_W'(WRITE_CYCLES - 1);
         logic             busy_q;
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
            end else if (busy_q) begin
               if (cnt_q == '0) busy_q <= 1'b0;
               else             cnt_q  <= cnt_q - 1'b1;
            end else if (start) begin
               busy_q <= 1'b1;
               cnt_q  <= LOAD;
            end
         end
         assign busy = busy_q;
         assign done = busy_q && (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/ee_prot_decode.sv
module ee_prot_decode
   import ee_status_pkg::*;
#(
   parameter int unsigned ADDR_W = 9
) (
   input  logic [1:0]        level,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int unsigned TOP = ADDR_W - 1;

   initial begin
      assert (ADDR_W >= 2) else $error("ADDR_W must be at least 2");
   end

   prot_level_e lvl;
   assign lvl = prot_level_e'(level);

   always_comb begin
      unique case (lvl)
         PROT_NONE:    hit = 1'b0;
         PROT_QUARTER: hit = addr[TOP] & addr[TOP-1];
         PROT_HALF:    hit = addr[TOP];
         PROT_ALL:     hit = 1'b1;
         default:      hit = 1'b1;
      endcase
   end

endmodule

// File: rtl/ee_guard_ctrl.sv
module ee_guard_ctrl
   import ee_status_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_set_we,
   input  logic       cmd_clr_we,
   input  logic       cmd_wr_status,
   input  logic [7:0] wr_status_data,
   input  logic       cmd_commit,
   input  logic       wp_n,
   input  logic       frame_active,
   input  logic       busy,
   input  logic       done,
   output logic       start,
   output logic       allowed,
   output logic       wel,
   output logic [7:0] keep_bits
);
   logic       frame_q;
   logic       cancel_q;
   logic       wel_q;
   logic [7:0] keep_q;
   logic       frame_rise;
   logic       take_status;

   assign frame_rise  = frame_active & ~frame_q;
   assign allowed     = wel_q & wp_n & ~cancel_q & ~busy;
   assign take_status = cmd_wr_status & allowed;
   assign start       = take_status | (cmd_commit & allowed);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q  <= 1'b0;
         cancel_q <= 1'b0;
      end else begin
         frame_q <= frame_active;
         if (frame_rise)                cancel_q <= ~wp_n;
         else if (frame_active && !wp_n) cancel_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q <= 1'b0;
      end else if (done) begin
         wel_q <= 1'b0;
      end else if (!busy) begin
         if (cmd_clr_we)            wel_q <= 1'b0;
         else if (cmd_set_we && wp_n) wel_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           keep_q <= '0;
      else if (take_status) keep_q <= wr_status_data & ST_WR_MASK;
   end

   assign wel       = wel_q;
   assign keep_bits = keep_q;

endmodule

// File: rtl/ee_status_guard.sv
module ee_status_guard
   import ee_status_pkg::*;
#(
   parameter int unsigned ADDR_W       = 9,
   parameter int unsigned WRITE_CYCLES = 500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_set_we,
   input  logic              cmd_clr_we,
   input  logic              cmd_wr_status,
   input  logic [7:0]        wr_status_data,
   input  logic              cmd_commit,
   input  logic              wp_n,
   input  logic              frame_active,
   input  logic [ADDR_W-1:0] query_addr,
   output logic [7:0]        status_byte,
   output logic              busy,
   output logic              write_allowed,
   output logic              addr_protected
);
   logic       start;
   logic       done;
   logic       wel;
   logic [7:0] keep_bits;
   logic [7:0] idle_byte;

   ee_wcycle_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .done  (done)
   );

   ee_guard_ctrl u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .cmd_set_we     (cmd_set_we),
      .cmd_clr_we     (cmd_clr_we),
      .cmd_wr_status  (cmd_wr_status),
      .wr_status_data (wr_status_data),
      .cmd_commit     (cmd_commit),
      .wp_n           (wp_n),
      .frame_active   (frame_active),
      .busy           (busy),
      .done           (done),
      .start          (start),
      .allowed        (write_allowed),
      .wel            (wel),
      .keep_bits      (keep_bits)
   );

   ee_prot_decode #(.ADDR_W(ADDR_W)) u_decode (
      .level (keep_bits[ST_BP_HI:ST_BP_LO]),
      .addr  (query_addr),
      .hit   (addr_protected)
   );

   always_comb begin
      idle_byte             = keep_bits;
      idle_byte[ST_WEL_BIT] = wel;
   end

   assign status_byte = busy ? ST_BUSY_VAL : idle_byte;

endmodule

// File: rtl/ee_status_guard_chk.sv
module ee_status_guard_chk #(
   parameter int unsigned ADDR_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_set_we,
   input logic              cmd_clr_we,
   input logic              cmd_wr_status,
   input logic              cmd_commit,
   input logic              wp_n,
   input logic [ADDR_W-1:0] query_addr,
   input logic [7:0]        status_byte,
   input logic              busy,
   input logic              write_allowed,
   input logic              addr_protected
);
   p_busy_reads_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> status_byte == 8'hFF);

   p_idle_layout_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (status_byte[7:4] == 4'h0 && status_byte[0] == 1'b0));

   p_set_blocked_by_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !status_byte[1] && cmd_set_we && !wp_n) |=> !status_byte[1]);

   p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_clr_we && !cmd_wr_status && !cmd_commit) |=> !status_byte[1]);

   p_latch_drops_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !status_byte[1]);

   p_start_needs_allowed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !write_allowed) |=> !busy);

   p_busy_no_allow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !write_allowed);

   p_level0_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && status_byte[3:2] == 2'b00) |-> !addr_protected);

   p_level3_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && status_byte[3:2] == 2'b11) |-> addr_protected);

   p_pin_low_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_n |-> !write_allowed);
endmodule

bind ee_status_guard ee_status_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cmd_set_we     (cmd_set_we),
   .cmd_clr_we     (cmd_clr_we),
   .cmd_wr_status  (cmd_wr_status),
   .cmd_commit     (cmd_commit),
   .wp_n           (wp_n),
   .query_addr     (query_addr),
   .status_byte    (status_byte),
   .busy           (busy),
   .write_allowed  (write_allowed),
   .addr_protected (addr_protected)
);

// File: tb/ee_status_guard_bench.sv
module ee_status_guard_bench;
   localparam int unsigned AW = 9;
   localparam int unsigned WC = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_set_we = 1'b0;
   logic          cmd_clr_we = 1'b0;
   logic          cmd_wr_status = 1'b0;
   logic [7:0]    wr_status_data = 8'h00;
   logic          cmd_commit = 1'b0;
   logic          wp_n = 1'b1;
   logic          frame_active = 1'b0;
   logic [AW-1:0] query_addr = '0;
   logic [7:0]    status_byte;
   logic          busy;
   logic          write_allowed;
   logic          addr_protected;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   ee_status_guard #(.ADDR_W(AW), .WRITE_CYCLES(WC)) u_ee_status_guard (
      .clk(clk), .rst_n(rst_n), .cmd_set_we(cmd_set_we), .cmd_clr_we(cmd_clr_we),
      .cmd_wr_status(cmd_wr_status), .wr_status_data(wr_status_data),
      .cmd_commit(cmd_commit), .wp_n(wp_n), .frame_active(frame_active),
      .query_addr(query_addr), .status_byte(status_byte), .busy(busy),
      .write_allowed(write_allowed), .addr_protected(addr_protected));

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check(string req, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic pulse_set();
      cmd_set_we = 1'b1; tick(); cmd_set_we = 1'b0;
   endtask

   task automatic pulse_clr();
      cmd_clr_we = 1'b1; tick(); cmd_clr_we = 1'b0;
   endtask

   task automatic pulse_status(input logic [7:0] d);
      wr_status_data = d; cmd_wr_status = 1'b1; tick(); cmd_wr_status = 1'b0;
   endtask

   // counts busy samples; injects ignored commands and a pin drop at sample 3
   task automatic run_cycle(input bit inject, output int n);
      n = 0;
      while (busy && n < 1000) begin
         n++;
         if (inject && n == 3) begin
            cmd_set_we = 1'b1; cmd_wr_status = 1'b1; wr_status_data = 8'h0C;
            cmd_commit = 1'b1; cmd_clr_we = 1'b0; wp_n = 1'b0;
         end
         tick();
         cmd_set_we = 1'b0; cmd_wr_status = 1'b0; cmd_commit = 1'b0; wp_n = 1'b1;
      end
   endtask

   initial begin
      int n;
      logic [7:0] cur;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      check("R10 reset status", status_byte, 8'h00);
      check("R4 reset busy", busy, 0);
      check("R6 reset allowed", write_allowed, 0);

      wp_n = 1'b0; pulse_set(); wp_n = 1'b1;
      check("R5 set with pin low", status_byte, 8'h00);

      pulse_status(8'hFF);
      check("R6 status write without latch busy", busy, 0);
      check("R6 status write without latch", status_byte, 8'h00);

      pulse_set();
      check("R5 set with pin high", status_byte, 8'h02);
      check("R6 allowed when enabled", write_allowed, 1);

      wp_n = 1'b0; pulse_clr(); wp_n = 1'b1;
      check("R5 clear with pin low", status_byte, 8'h00);

      cmd_set_we = 1'b1; cmd_clr_we = 1'b1; tick();
      cmd_set_we = 1'b0; cmd_clr_we = 1'b0;
      check("R5 clear wins", status_byte, 8'h00);

      for (int lvl = 0; lvl < 4; lvl++) begin
         pulse_set();
         pulse_status(8'hF3 | 8'(lvl << 2));
         check("R2 busy reads all ones", status_byte, 8'hFF);
         check("R2 busy raised", busy, 1);
         run_cycle(lvl == 1, n);
         check("R2 R8 R9 cycle length", n, WC);
         check("R7 R4 R9 status after write", status_byte, lvl << 2);
         for (int a = 0; a < (1 << AW); a++) begin
            int exp;
            query_addr = AW'(a);
            #1;
            case (lvl)
               0: exp = 0;
               1: exp = (a >= 384) ? 1 : 0;
               2: exp = (a >= 256) ? 1 : 0;
               default: exp = 1;
            endcase
            check("R3 protect decode", addr_protected, exp);
         end
      end

      pulse_set();
      cmd_commit = 1'b1; tick(); cmd_commit = 1'b0;
      check("R2 commit starts cycle", busy, 1);
      run_cycle(1'b0, n);
      check("R2 commit cycle length", n, WC);
      check("R4 latch cleared after commit", status_byte, 8'h0C);

      pulse_set();
      frame_active = 1'b1; tick();
      wp_n = 1'b0; tick();
      wp_n = 1'b1; tick();
      check("R8 cancel drops allowed", write_allowed, 0);
      frame_active = 1'b0; cmd_commit = 1'b1; tick(); cmd_commit = 1'b0;
      check("R8 cancelled commit", busy, 0);
      cur = status_byte;
      check("R8 state kept after cancel", cur, 8'h0E);
      frame_active = 1'b1; tick();
      check("R8 new frame restores allowed", write_allowed, 1);
      frame_active = 1'b0; cmd_commit = 1'b1; tick(); cmd_commit = 1'b0;
      check("R6 commit after new frame", busy, 1);
      run_cycle(1'b0, n);
      check("R4 latch after final cycle", status_byte, 8'h0C);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule